// File: doc/BRIEF.md
# UART Transmit/Receive FIFO Pair with Watermark Requests

This block holds the transmit and receive byte queues that sit between a byte-wide register interface and a serial shifter. Software writes bytes for sending into one register address and reads received bytes from the same address. The transmit shifter takes the oldest byte through a pop strobe. The receive shifter delivers each byte through a push strobe. Serial shifting itself is outside this block.

Each direction has a depth fixed at build time by a 3-bit code, and the queue holds 2^(code+1) entries. Software can read both codes from a parameter register. Each queue can also be switched down to a single entry. Two watermark registers set the point at which the block raises its request lines. The transmit request asks for more data while the transmit queue is at or below its mark. The receive request asks for draining once the receive queue reaches its mark. Sticky error flags record a push into a full queue and a read from an empty receive queue. A control register can route these flags to an interrupt line.

Register addresses (3-bit): 0 data, 1 parameter, 2 control, 3 status, 4 transmit watermark, 5 receive watermark, 6 transmit count, 7 reads zero.

Top module: `uart_fifo_wm`

## Requirements
- R1: After reset, status (addr 3) reads 0xC0, transmit count (addr 6) reads 0, `tx_req` is 1, `rx_req` is 0 and `err_irq` is 0. The transmit watermark resets to 0 and the receive watermark resets to 1.
- R2: The parameter register (addr 1) returns the transmit depth code in bits [6:4] and the receive depth code in bits [2:0], and writes cannot change these fields. Bit 7 (transmit enable) and bit 3 (receive enable) are writable and reset to 0. With the default codes of 2, the register reads 0x22 after reset and 0xAA once both enables are set.
- R3: Bytes written to addr 0 appear on `tx_byte` in write order, with `tx_valid` high while the transmit queue is not empty. Each `tx_pop` removes the head. Addr 6 reports the number of stored transmit entries.
- R4: A byte given with `rx_push` is stored in the receive queue. A read of addr 0 returns the oldest receive byte on `reg_rdata` in that same cycle and removes it.
- R5: While a direction's enable bit is 0, that queue holds at most one entry.
- R6: A push into a full queue is discarded, leaves the stored contents unchanged and sets a sticky status flag: bit 1 for transmit, bit 2 for receive. If a pop of the same queue happens in the same cycle, the push is accepted and no flag is set.
- R7: A read of addr 0 while the receive queue is empty sets sticky status bit 0 and leaves the queue unchanged.
- R8: A status write clears each flag whose bit is 1 in the written data and leaves the other flags alone. An error event in the same cycle as a clear leaves its flag set.
- R9: Writing control (addr 2) with bit 7 empties the transmit queue, and with bit 6 empties the receive queue, both in one cycle. The flush bits read back as 0, and the error flags are not altered. Status bits 7 and 6 report transmit empty and receive empty.
- R10: `tx_req` is 1 exactly when the transmit count is at most the transmit watermark (addr 4). `rx_req` is 1 exactly when the receive count is at least the receive watermark (addr 5).
- R11: `err_irq` is the OR of the status flags whose enable bits are set in control bits [2:0], at the same bit positions as the flags.
- R12: A write to addr 0 in the same cycle as `tx_pop` on a non-empty transmit queue leaves the count unchanged and keeps byte order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of addr 0 pops the receive queue) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from the address |
| tx_pop | input | 1 | Transmit shifter takes the head byte |
| tx_byte | output | 8 | Transmit head byte |
| tx_valid | output | 1 | Transmit queue not empty |
| rx_push | input | 1 | Receive shifter delivers a byte |
| rx_byte | input | 8 | Received byte |
| tx_req | output | 1 | Transmit watermark request |
| rx_req | output | 1 | Receive watermark request |
| err_irq | output | 1 | Enabled error flag interrupt |

## Verification
A queue can be pushed and popped in the same cycle. The bench raises `tx_pop` during a data write, first on a completely full transmit queue and then on a one-entry queue. The judgement is that the count stays put, no overflow flag appears, and the scoreboard sees bytes leave in write order. The second collision is a receive push into a full queue in the same cycle as a status write that clears the receive overflow flag. There the flag must read back still set.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    typedef enum logic [2:0] {
        A_DATA  = 3'd0,
        A_PARAM = 3'd1,
        A_CTRL  = 3'd2,
        A_STAT  = 3'd3,
        A_TXWM  = 3'd4,
        A_RXWM  = 3'd5,
        A_TXCNT = 3'd6,
        A_SPARE = 3'd7
    } reg_addr_e;

    // parameter register bit positions
    localparam int P_TXEN = 7;
    localparam int P_RXEN = 3;
    // control register flush bit positions
    localparam int C_TXFL = 7;
    localparam int C_RXFL = 6;
    // status register bit positions
    localparam int S_TXEMP = 6 + 1;
    localparam int S_RXEMP = 6;
    localparam int F_RXOV  = 2;
    localparam int F_TXOV  = 1;
    localparam int F_RXUN  = 0;

    function automatic int depth_of(input int code);
        return 1 << (code + 1);
    endfunction

endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          full_mode,
    input  logic          flush,
    input  logic          push,
    input  logic [7:0]    push_data,
    input  logic          pop,
    output logic [7:0]    head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          ovf_evt,
    output logic          unf_evt
);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t       s_d, s_q;
    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];
    logic [CW-1:0] cap;
    logic       do_push, do_pop;

    always_comb begin
        s_d     = s_q;
        mem_d   = mem_q;
        cap     = full_mode ? CW'(DEPTH) : CW'(1);
        full    = (s_q.cnt >= cap);
        empty   = (s_q.cnt == '0);
        do_pop  = pop && !empty;
        do_push = push && (!full || do_pop);
        ovf_evt = push && !do_push && !flush;
        unf_evt = pop && empty && !flush;
        if (flush) begin
            s_d = '0;
        end else begin
            if (do_push) begin
                mem_d[s_q.wp] = push_data;
                s_d.wp        = s_q.wp + PW'(1);
            end
            if (do_pop) begin
                s_d.rp = s_q.rp + PW'(1);
            end
            s_d.cnt = s_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign head  = mem_q[s_q.rp];
    assign count = s_q.cnt;

endmodule

// File: rtl/uart_wm_cmp.sv
module uart_wm_cmp #(
    parameter int CW       = 4,
    parameter bit AT_MOST  = 1'b1,
    localparam int W       = (CW > 8) ? CW : 8
) (
    input  logic [CW-1:0] level,
    input  logic [7:0]    mark,
    output logic          hit
);

    logic [W-1:0] lvl_w, mark_w;

    always_comb begin
        lvl_w  = W'(level);
        mark_w = W'(mark);
    end

    generate
        if (AT_MOST) begin : g_le
            assign hit = (lvl_w <= mark_w);
        end else begin : g_ge
            assign hit = (lvl_w >= mark_w);
        end
    endgenerate

endmodule

// File: rtl/uart_fifo_wm.sv
module uart_fifo_wm
    import uart_fifo_pkg::*;
#(
    parameter int TX_CODE = 2,
    parameter int RX_CODE = 2,
    localparam int TX_DEPTH = depth_of(TX_CODE),
    localparam int RX_DEPTH = depth_of(RX_CODE),
    localparam int TX_CW = $clog2(TX_DEPTH) + 1,
    localparam int RX_CW = $clog2(RX_DEPTH) + 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       tx_pop,
    output logic [7:0] tx_byte,
    output logic       tx_valid,
    input  logic       rx_push,
    input  logic [7:0] rx_byte,
    output logic       tx_req,
    output logic       rx_req,
    output logic       err_irq
);

    typedef struct packed {
        logic       tx_en;
        logic       rx_en;
        logic [2:0] ie;
        logic [2:0] flags;
        logic [7:0] tx_wm;
        logic [7:0] rx_wm;
    } regs_t;

    regs_t r_d, r_q;

    logic             wr_data, rd_data, wr_ctrl, wr_stat;
    logic             tx_flush, rx_flush;
    logic [7:0]       tx_head, rx_head;
    logic [TX_CW-1:0] tx_cnt;
    logic [RX_CW-1:0] rx_cnt;
    logic             tx_full, tx_empty, tx_ovf, tx_unf_unused;
    logic             rx_full, rx_empty, rx_ovf, rx_unf;
    logic [2:0]       err_flags;
    logic             tx_en, rx_en;

    // register strobes
    assign wr_data  = reg_wr && (reg_addr == A_DATA);
    assign rd_data  = reg_rd && (reg_addr == A_DATA);
    assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
    assign wr_stat  = reg_wr && (reg_addr == A_STAT);
    assign tx_flush = wr_ctrl && reg_wdata[C_TXFL];
    assign rx_flush = wr_ctrl && reg_wdata[C_RXFL];

    uart_byte_fifo #(.DEPTH(TX_DEPTH)) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .full_mode (r_q.tx_en),
        .flush     (tx_flush),
        .push      (wr_data),
        .push_data (reg_wdata),
        .pop       (tx_pop),
        .head      (tx_head),
        .count     (tx_cnt),
        .full      (tx_full),
        .empty     (tx_empty),
        .ovf_evt   (tx_ovf),
        .unf_evt   (tx_unf_unused)
    );

    uart_byte_fifo #(.DEPTH(RX_DEPTH)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .full_mode (r_q.rx_en),
        .flush     (rx_flush),
        .push      (rx_push),
        .push_data (rx_byte),
        .pop       (rd_data),
        .head      (rx_head),
        .count     (rx_cnt),
        .full      (rx_full),
        .empty     (rx_empty),
        .ovf_evt   (rx_ovf),
        .unf_evt   (rx_unf)
    );

    uart_wm_cmp #(.CW(TX_CW), .AT_MOST(1'b1)) u_tx_wm (
        .level (tx_cnt),
        .mark  (r_q.tx_wm),
        .hit   (tx_req)
    );

    uart_wm_cmp #(.CW(RX_CW), .AT_MOST(1'b0)) u_rx_wm (
        .level (rx_cnt),
        .mark  (r_q.rx_wm),
        .hit   (rx_req)
    );

    // next register state
    always_comb begin
        logic [2:0] clr_mask;
        logic [2:0] set_mask;
        r_d      = r_q;
        clr_mask = wr_stat ? reg_wdata[2:0] : 3'b000;
        set_mask = '0;
        set_mask[F_RXOV] = rx_ovf;
        set_mask[F_TXOV] = tx_ovf;
        set_mask[F_RXUN] = rx_unf;
        r_d.flags = (r_q.flags & ~clr_mask) | set_mask;
        if (reg_wr) begin
            case (reg_addr)
                A_PARAM: begin
                    r_d.tx_en = reg_wdata[P_TXEN];
                    r_d.rx_en = reg_wdata[P_RXEN];
                end
                A_CTRL:  r_d.ie    = reg_wdata[2:0];
                A_TXWM:  r_d.tx_wm = reg_wdata;
                A_RXWM:  r_d.rx_wm = reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.rx_wm <= 8'd1;
        end else begin
            r_q <= r_d;
        end
    end

    // read path
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_DATA:  reg_rdata = rx_head;
            A_PARAM: reg_rdata = {r_q.tx_en, 3'(TX_CODE), r_q.rx_en, 3'(RX_CODE)};
            A_CTRL:  reg_rdata = {5'b0, r_q.ie};
            A_STAT: begin
                reg_rdata[S_TXEMP] = tx_empty;
                reg_rdata[S_RXEMP] = rx_empty;
                reg_rdata[2:0]     = r_q.flags;
            end
            A_TXWM:  reg_rdata = r_q.tx_wm;
            A_RXWM:  reg_rdata = r_q.rx_wm;
            A_TXCNT: reg_rdata = 8'(tx_cnt);
            default: reg_rdata = '0;
        endcase
    end

    assign tx_byte   = tx_head;
    assign tx_valid  = !tx_empty;
    assign err_irq   = |(r_q.flags & r_q.ie);
    assign err_flags = r_q.flags;
    assign tx_en     = r_q.tx_en;
    assign rx_en     = r_q.rx_en;

endmodule

// File: rtl/uart_fifo_wm_chk.sv
module uart_fifo_wm_chk #(
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        reg_wr,
    input logic                        reg_rd,
    input logic [2:0]                  reg_addr,
    input logic [7:0]                  reg_wdata,
    input logic                        tx_pop,
    input logic [$clog2(TX_DEPTH):0]   tx_cnt,
    input logic [$clog2(RX_DEPTH):0]   rx_cnt,
    input logic                        tx_full,
    input logic                        rx_en,
    input logic [2:0]                  err_flags
);

    // R3
    tx_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cnt <= ($clog2(TX_DEPTH) + 1)'(TX_DEPTH));

    // R5
    rx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && rx_cnt <= 1 && !(reg_wr && reg_addr == 3'd1)) |=> (rx_cnt <= 1));

    // R6
    tx_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd0 && !tx_full && !tx_pop) |=> (tx_cnt == $past(tx_cnt) + 1'b1));

    // R7
    rx_unf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 3'd0 && rx_cnt == 0) |=> err_flags[0]);

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flags[1] && !(reg_wr && reg_addr == 3'd3 && reg_wdata[1])) |=> err_flags[1]);

    // R9
    tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd2 && reg_wdata[7]) |=> (tx_cnt == 0));

    // R12
    tx_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd0 && tx_pop && tx_cnt != 0) |=> $stable(tx_cnt));

endmodule

bind uart_fifo_wm uart_fifo_wm_chk #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .tx_pop    (tx_pop),
    .tx_cnt    (tx_cnt),
    .rx_cnt    (rx_cnt),
    .tx_full   (tx_full),
    .rx_en     (rx_en),
    .err_flags (err_flags)
);

// File: tb/tb_uart_fifo_wm.sv
module tb_uart_fifo_wm;

    localparam int DEPTH = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       tx_pop = 1'b0;
    logic [7:0] tx_byte;
    logic       tx_valid;
    logic       rx_push = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       tx_req, rx_req, err_irq;

    int checks = 0;
    int errors = 0;
    int tx_cap = 1;
    int rx_cap = 1;
    bit done = 1'b0;
    logic [7:0] tx_q[$];
    logic [7:0] rx_q[$];

    always #5 clk = ~clk;

    uart_fifo_wm dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_pop(tx_pop), .tx_byte(tx_byte), .tx_valid(tx_valid),
        .rx_push(rx_push), .rx_byte(rx_byte),
        .tx_req(tx_req), .rx_req(rx_req), .err_irq(err_irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor for the transmit side (R3)
    always @(negedge clk) begin
        if (rst_n && tx_pop) begin
            if (tx_q.size() == 0) begin
                chk("R3 valid on empty pop", {7'b0, tx_valid}, 8'h00);
            end else begin
                chk("R3 tx_valid", {7'b0, tx_valid}, 8'h01);
                chk("R3 tx order", tx_byte, tx_q[0]);
                void'(tx_q.pop_front());
            end
        end
    end

    // all ops start and end at 1 ns after a rising edge
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        if (a == 3'd0 && (tx_q.size() < tx_cap || (tx_pop && tx_q.size() > 0)))
            tx_q.push_back(d);
        if (a == 3'd2 && d[7]) tx_q.delete();
        if (a == 3'd2 && d[6]) rx_q.delete();
        if (a == 3'd1) begin
            tx_cap = d[7] ? DEPTH : 1;
            rx_cap = d[3] ? DEPTH : 1;
        end
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        reg_rd = 1'b1; reg_addr = a;
        #4 v = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic rd_rx(input string req);
        logic [7:0] v;
        logic [7:0] e;
        e = rx_q.pop_front();
        rd(3'd0, v);
        chk(req, v, e);
    endtask

    task automatic rx_in(input logic [7:0] d);
        rx_push = 1'b1; rx_byte = d;
        if (rx_q.size() < rx_cap) rx_q.push_back(d);
        @(posedge clk); #1;
        rx_push = 1'b0;
    endtask

    task automatic txpop();
        tx_pop = 1'b1;
        @(posedge clk); #1;
        tx_pop = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset state
        rd_chk("R1 status", 3'd3, 8'hC0);
        rd_chk("R1 txcount", 3'd6, 8'h00);
        chk("R1 tx_req", {7'b0, tx_req}, 8'h01);
        chk("R1 rx_req", {7'b0, rx_req}, 8'h00);
        chk("R1 err_irq", {7'b0, err_irq}, 8'h00);
        rd_chk("R1 rx watermark", 3'd5, 8'h01);
        // R2 parameter register
        rd_chk("R2 param reset", 3'd1, 8'h22);
        wr(3'd1, 8'hFF);
        rd_chk("R2 param enables, codes fixed", 3'd1, 8'hAA);

        // R3 / R10 transmit basics
        wr(3'd0, 8'h11); wr(3'd0, 8'h22); wr(3'd0, 8'h33);
        rd_chk("R3 txcount 3", 3'd6, 8'h03);
        chk("R10 tx_req 3>0", {7'b0, tx_req}, 8'h00);
        wr(3'd4, 8'd3);
        chk("R10 tx_req 3<=3", {7'b0, tx_req}, 8'h01);
        wr(3'd4, 8'd2);
        chk("R10 tx_req 3>2", {7'b0, tx_req}, 8'h00);
        txpop();
        chk("R10 tx_req 2<=2", {7'b0, tx_req}, 8'h01);
        txpop(); txpop();
        rd_chk("R3 txcount drained", 3'd6, 8'h00);

        // R6 transmit overflow, R11 interrupt, R8 sticky and clear
        for (int i = 0; i < DEPTH; i++) wr(3'd0, 8'h40 + 8'(i));
        rd_chk("R3 txcount full", 3'd6, 8'h08);
        wr(3'd0, 8'hEE);
        rd_chk("R6 tx overflow flag", 3'd3, 8'h42);
        rd_chk("R6 txcount unchanged", 3'd6, 8'h08);
        chk("R11 irq masked", {7'b0, err_irq}, 8'h00);
        wr(3'd2, 8'h02);
        chk("R11 irq enabled", {7'b0, err_irq}, 8'h01);
        wr(3'd3, 8'h00);
        rd_chk("R8 sticky", 3'd3, 8'h42);
        wr(3'd3, 8'h02);
        rd_chk("R8 cleared", 3'd3, 8'h40);
        chk("R11 irq after clear", {7'b0, err_irq}, 8'h00);

        // R12 push and pop together on a full queue
        tx_pop = 1'b1;
        wr(3'd0, 8'h99);
        tx_pop = 1'b0;
        rd_chk("R12 count held when full", 3'd6, 8'h08);
        rd_chk("R6 no overflow with pop", 3'd3, 8'h40);

        // R9 transmit flush keeps flags
        wr(3'd0, 8'hEF);
        wr(3'd2, 8'h82);
        rd_chk("R9 tx flushed", 3'd6, 8'h00);
        rd_chk("R9 flag kept", 3'd3, 8'hC2);
        rd_chk("R9 flush bit reads 0", 3'd2, 8'h02);
        wr(3'd3, 8'h02);

        // R12 push and pop together at one entry
        wr(3'd0, 8'h51);
        tx_pop = 1'b1;
        wr(3'd0, 8'h52);
        tx_pop = 1'b0;
        rd_chk("R12 count held at one", 3'd6, 8'h01);
        txpop();

        // R4 receive path, R10 receive watermark
        rx_in(8'hA1); rx_in(8'hA2); rx_in(8'hA3);
        chk("R10 rx_req 3>=1", {7'b0, rx_req}, 8'h01);
        rd_rx("R4 rx byte 1"); rd_rx("R4 rx byte 2"); rd_rx("R4 rx byte 3");
        chk("R10 rx_req 0<1", {7'b0, rx_req}, 8'h00);
        rd_chk("R4 status empty", 3'd3, 8'hC0);
        wr(3'd5, 8'd4);
        rx_in(8'hB0); rx_in(8'hB1); rx_in(8'hB2);
        chk("R10 rx_req 3<4", {7'b0, rx_req}, 8'h00);
        rx_in(8'hB3);
        chk("R10 rx_req 4>=4", {7'b0, rx_req}, 8'h01);

        // R6 receive overflow
        for (int i = 0; i < 4; i++) rx_in(8'hC0 + 8'(i));
        rx_in(8'hDD);
        rd_chk("R6 rx overflow flag", 3'd3, 8'h84);
        for (int i = 0; i < DEPTH; i++) rd_rx("R6 rx contents kept");
        // R7 underflow
        begin
            logic [7:0] v;
            rd(3'd0, v);
        end
        rd_chk("R7 underflow flag", 3'd3, 8'hC5);
        wr(3'd3, 8'h07);
        rd_chk("R8 clear all", 3'd3, 8'hC0);

        // R8 set wins over clear
        for (int i = 0; i < DEPTH; i++) rx_in(8'h70 + 8'(i));
        rx_push = 1'b1; rx_byte = 8'hFE;
        wr(3'd3, 8'h04);
        rx_push = 1'b0;
        rd_chk("R8 set beats clear", 3'd3, 8'h84);
        // R9 receive flush
        wr(3'd2, 8'h42);
        rd_chk("R9 rx flushed, flag kept", 3'd3, 8'hC4);
        wr(3'd3, 8'h04);

        // R5 single-entry mode
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h61); wr(3'd0, 8'h62);
        rd_chk("R5 tx holds one", 3'd6, 8'h01);
        rd_chk("R5 tx overflow", 3'd3, 8'h42);
        txpop();
        rx_in(8'h71); rx_in(8'h72);
        rd_chk("R5 rx overflow", 3'd3, 8'h86);
        rd_rx("R5 rx keeps first");
        rd_chk("R5 rx empty after one", 3'd3, 8'hC6);

        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule